// File: doc/BRIEF.md
# Packed Twelve-Bit Lookup Table with AXI4-Lite Access

This block keeps a table of 256 rows. Each row is 96 bits wide and holds eight unsigned 12-bit values, so the table carries 2048 values. A host reaches the table through an AXI4-Lite slave. Each row appears in the address map as a group of four 32-bit words starting at `0x1000 + 16*row`. The first three words hold the row's bits from low to high. The fourth word is a hole that reads as zero.

Many 12-bit values do not fit inside one bus word and spread across two of them. The host therefore writes whole rows, or it writes both words that hold a value. A second port serves the datapath. It takes an 11-bit value index and returns that value two cycles later, together with a valid pulse. The lookup port has no back-pressure: the block takes a request in every cycle in which `lk_req_valid` is high, and the consumer must accept each response in the cycle it appears. On the bus side each channel follows the AXI4-Lite valid/ready rules. A response stays stable until its ready is seen, and only one write and one read may be in flight at a time.

Top module: `lut_axil_packed`

## Requirements
- R1: A byte address A with 0x1000 <= A <= 0x1FFF selects row (A-0x1000)>>4 and word ((A-0x1000)>>2)&3. Address bits [1:0] are ignored. Word k, for k in 0..2, maps to row bits [32k+31:32k]. A write there answers OKAY (bresp 2'b00), and a later read returns the same bits with OKAY.
- R2: Word 3 of every row is a hole. A read of it returns 0 with OKAY. A write to it answers OKAY and changes no table bit.
- R3: Value j of a row (j in 0..7) is held in row bits [12j+11:12j], so value 0 sits in the least significant bits.
- R4: Each set bit b of the write strobe updates byte b of the selected word. Bytes whose strobe bit is clear keep their old contents.
- R5: An address below 0x1000 or above 0x1FFF answers SLVERR (2'b10). A read returns data 0, and a write changes no table bit.
- R6: A lookup request with index i returns value i%8 of row i/8 on `lk_rsp_value`, with `lk_rsp_valid` high, exactly two rising edges after the edge that samples the request.
- R7: The block takes back-to-back lookup requests in every cycle. `lk_rsp_valid` is high only two cycles after a request, and `lk_rsp_value` is 0 while `lk_rsp_valid` is low.
- R8: A write completes only when address and data are both valid. Then `axi_awready` and `axi_wready` rise together. `axi_bvalid` and `axi_bresp` hold until `axi_bready`. `axi_rvalid`, `axi_rdata` and `axi_rresp` hold until `axi_rready`. No new request is taken on a channel while its response is pending.
- R9: A value that spans two bus words, such as value 2 (bits [35:24]), changes only in the part held by the word that is written. A write to row word 0 alone changes bits [31:24] of value 2 and leaves bits [35:32] as they were.
- R10: After reset, `axi_bvalid`, `axi_rvalid` and `lk_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| axi_awaddr | input | 32 | Write address |
| axi_awvalid | input | 1 | Write address valid |
| axi_awready | output | 1 | Write address accepted |
| axi_wdata | input | 32 | Write data |
| axi_wstrb | input | 4 | Write byte strobes |
| axi_wvalid | input | 1 | Write data valid |
| axi_wready | output | 1 | Write data accepted |
| axi_bresp | output | 2 | Write response code |
| axi_bvalid | output | 1 | Write response valid |
| axi_bready | input | 1 | Write response taken |
| axi_araddr | input | 32 | Read address |
| axi_arvalid | input | 1 | Read address valid |
| axi_arready | output | 1 | Read address accepted |
| axi_rdata | output | 32 | Read data |
| axi_rresp | output | 2 | Read response code |
| axi_rvalid | output | 1 | Read data valid |
| axi_rready | input | 1 | Read data taken |
| lk_req_valid | input | 1 | Lookup request present |
| lk_req_idx | input | 11 | Value index, 0..2047 |
| lk_rsp_valid | output | 1 | Lookup result present |
| lk_rsp_value | output | 12 | Looked-up value |

## Verification
Suppose the row, word or byte decode is wrong, or a hole word is stored by mistake. Then the next read of the affected address returns a wrong word. The lookup sweep also shows the bad word, once per value it touches, two cycles after the index is presented. A bad slot select or field offset shows up only at the lookup port, so every one of the 2048 indices is checked against a model built from the words the bench wrote. A handshake register that is stuck or released early shows up on the very next edge as a dropped or repeated response.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } resp_e;

  typedef enum logic [1:0] {
    REGION_DATA = 2'd0,
    REGION_HOLE = 2'd1,
    REGION_MISS = 2'd2
  } region_e;
endpackage

// File: rtl/lut_addr_decode.sv
module lut_addr_decode
  import lut_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_ADDR = 32'h1000,
  parameter int DATA_W    = 32,
  parameter int SLICES    = 3,
  parameter int ENT_W     = 8,
  parameter int SL_W      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ENT_W-1:0]  entry,
  output logic [SL_W-1:0]   slice
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam int TOP_SH  = BYTE_SH + SL_W + ENT_W;

  logic [ADDR_W-1:0] off;
  logic              in_win;

  always_comb begin
    off    = addr - ADDR_W'(BASE_ADDR);
    in_win = (addr >= ADDR_W'(BASE_ADDR)) && ((off >> TOP_SH) == '0);
    entry  = off[BYTE_SH+SL_W +: ENT_W];
    slice  = off[BYTE_SH +: SL_W];
    if (!in_win)
      region = REGION_MISS;
    else if (slice >= SL_W'(SLICES))
      region = REGION_HOLE;
    else
      region = REGION_DATA;
  end
endmodule

// File: rtl/lut_store.sv
module lut_store #(
  parameter int ENTRIES = 256,
  parameter int DATA_W  = 32,
  parameter int SLICES  = 3,
  parameter int ENT_W   = 8,
  parameter int SL_W    = 2
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ENT_W-1:0]         wr_entry,
  input  logic [SL_W-1:0]          wr_slice,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/8-1:0]      wr_strb,
  input  logic [ENT_W-1:0]         rd_entry,
  output logic [SLICES*DATA_W-1:0] rd_row,
  input  logic [ENT_W-1:0]         lk_entry,
  output logic [SLICES*DATA_W-1:0] lk_row
);
  localparam int ROW_W  = SLICES * DATA_W;
  localparam int STRB_W = DATA_W / 8;

  logic [ROW_W-1:0] mem [ENTRIES];

  // byte-granular update of one 32-bit slice of one row
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int s = 0; s < SLICES; s++) begin
        if (wr_slice == SL_W'(s)) begin
          for (int b = 0; b < STRB_W; b++) begin
            if (wr_strb[b])
              mem[wr_entry][s*DATA_W + b*8 +: 8] <= wr_data[b*8 +: 8];
          end
        end
      end
    end
  end

  assign rd_row = mem[rd_entry];
  assign lk_row = mem[lk_entry];
endmodule

// File: rtl/lut_field_pick.sv
module lut_field_pick #(
  parameter int FIELDS  = 8,
  parameter int FIELD_W = 12,
  parameter int ROW_W   = 96,
  parameter int ENT_W   = 8,
  parameter int SLOT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ENT_W+SLOT_W-1:0] req_idx,
  output logic [ENT_W-1:0]        lk_entry,
  input  logic [ROW_W-1:0]        lk_row,
  output logic                    rsp_valid,
  output logic [FIELD_W-1:0]      rsp_value
);
  logic [ROW_W-1:0]   row_q;
  logic [SLOT_W-1:0]  slot_q;
  logic               v1_q;
  logic [FIELD_W-1:0] pick;

  assign lk_entry = req_idx[SLOT_W +: ENT_W];

  // stage 1: capture the addressed row and the slot number
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      row_q  <= '0;
      slot_q <= '0;
    end else begin
      v1_q <= req_valid;
      if (req_valid) begin
        row_q  <= lk_row;
        slot_q <= req_idx[SLOT_W-1:0];
      end
    end
  end

  always_comb begin
    pick = '0;
    for (int j = 0; j < FIELDS; j++)
      if (slot_q == SLOT_W'(j))
        pick = row_q[j*FIELD_W +: FIELD_W];
  end

  // stage 2: present the field, zero when idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_value <= '0;
    end else begin
      rsp_valid <= v1_q;
      rsp_value <= v1_q ? pick : '0;
    end
  end

  p_lookup_lat_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 rsp_valid);

  p_no_spurious_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid, 2));

  p_idle_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_value == '0);
endmodule

// File: rtl/lut_axil_port.sv
module lut_axil_port
  import lut_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_ADDR = 32'h1000,
  parameter int DATA_W    = 32,
  parameter int SLICES    = 3,
  parameter int ENT_W     = 8,
  parameter int SL_W      = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        axi_awaddr,
  input  logic                     axi_awvalid,
  output logic                     axi_awready,
  input  logic [DATA_W-1:0]        axi_wdata,
  input  logic [DATA_W/8-1:0]      axi_wstrb,
  input  logic                     axi_wvalid,
  output logic                     axi_wready,
  output logic [1:0]               axi_bresp,
  output logic                     axi_bvalid,
  input  logic                     axi_bready,
  input  logic [ADDR_W-1:0]        axi_araddr,
  input  logic                     axi_arvalid,
  output logic                     axi_arready,
  output logic [DATA_W-1:0]        axi_rdata,
  output logic [1:0]               axi_rresp,
  output logic                     axi_rvalid,
  input  logic                     axi_rready,
  output logic                     wr_en,
  output logic [ENT_W-1:0]         wr_entry,
  output logic [SL_W-1:0]          wr_slice,
  output logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W/8-1:0]      wr_strb,
  output logic [ENT_W-1:0]         rd_entry,
  input  logic [SLICES*DATA_W-1:0] rd_row
);
  region_e           w_region, r_region;
  logic [SL_W-1:0]   r_slice;
  logic              wr_go, rd_go;
  logic              bvalid_q, rvalid_q;
  resp_e             bresp_q, rresp_q;
  logic [DATA_W-1:0] rdata_q, rd_word;

  lut_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W),
    .SLICES(SLICES), .ENT_W(ENT_W), .SL_W(SL_W)
  ) u_wdec (
    .addr(axi_awaddr), .region(w_region), .entry(wr_entry), .slice(wr_slice)
  );

  lut_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W),
    .SLICES(SLICES), .ENT_W(ENT_W), .SL_W(SL_W)
  ) u_rdec (
    .addr(axi_araddr), .region(r_region), .entry(rd_entry), .slice(r_slice)
  );

  // write channel: address and data taken together, one response outstanding
  assign wr_go       = axi_awvalid && axi_wvalid && !bvalid_q;
  assign axi_awready = wr_go;
  assign axi_wready  = wr_go;
  assign wr_en       = wr_go && (w_region == REGION_DATA);
  assign wr_data     = axi_wdata;
  assign wr_strb     = axi_wstrb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      bresp_q  <= RESP_OKAY;
    end else if (wr_go) begin
      bvalid_q <= 1'b1;
      bresp_q  <= (w_region == REGION_MISS) ? RESP_SLVERR : RESP_OKAY;
    end else if (axi_bready) begin
      bvalid_q <= 1'b0;
    end
  end

  assign axi_bvalid = bvalid_q;
  assign axi_bresp  = bresp_q;

  // read channel
  assign rd_go       = axi_arvalid && !rvalid_q;
  assign axi_arready = !rvalid_q;

  always_comb begin
    rd_word = '0;
    for (int s = 0; s < SLICES; s++)
      if (r_slice == SL_W'(s))
        rd_word = rd_row[s*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rresp_q  <= RESP_OKAY;
      rdata_q  <= '0;
    end else if (rd_go) begin
      rvalid_q <= 1'b1;
      rresp_q  <= (r_region == REGION_MISS) ? RESP_SLVERR : RESP_OKAY;
      rdata_q  <= (r_region == REGION_DATA) ? rd_word : '0;
    end else if (axi_rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign axi_rvalid = rvalid_q;
  assign axi_rresp  = rresp_q;
  assign axi_rdata  = rdata_q;

  p_bresp_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    axi_bvalid && !axi_bready |=> axi_bvalid && $stable(axi_bresp));

  p_rresp_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    axi_rvalid && !axi_rready |=> axi_rvalid && $stable(axi_rdata) && $stable(axi_rresp));

  p_slverr_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    axi_rvalid && axi_rresp == RESP_SLVERR |-> axi_rdata == '0);

  p_hole_reads_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && r_region == REGION_HOLE |=> axi_rdata == '0 && axi_rresp == RESP_OKAY);

  p_miss_err_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && w_region == REGION_MISS |=> axi_bresp == RESP_SLVERR);
endmodule

// File: rtl/lut_axil_packed.sv
module lut_axil_packed #(
  parameter int ADDR_W    = 32,
  parameter int BASE_ADDR = 32'h1000,
  parameter int DATA_W    = 32,
  parameter int ENTRIES   = 256,
  parameter int FIELDS    = 8,
  parameter int FIELD_W   = 12,
  localparam int SLICES   = (FIELDS * FIELD_W + DATA_W - 1) / DATA_W,
  localparam int SL_W     = $clog2(SLICES + 1),
  localparam int ENT_W    = $clog2(ENTRIES),
  localparam int SLOT_W   = $clog2(FIELDS),
  localparam int IDX_W    = ENT_W + SLOT_W,
  localparam int ROW_W    = SLICES * DATA_W,
  localparam int STRB_W   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  axi_awaddr,
  input  logic               axi_awvalid,
  output logic               axi_awready,
  input  logic [DATA_W-1:0]  axi_wdata,
  input  logic [STRB_W-1:0]  axi_wstrb,
  input  logic               axi_wvalid,
  output logic               axi_wready,
  output logic [1:0]         axi_bresp,
  output logic               axi_bvalid,
  input  logic               axi_bready,
  input  logic [ADDR_W-1:0]  axi_araddr,
  input  logic               axi_arvalid,
  output logic               axi_arready,
  output logic [DATA_W-1:0]  axi_rdata,
  output logic [1:0]         axi_rresp,
  output logic               axi_rvalid,
  input  logic               axi_rready,
  input  logic               lk_req_valid,
  input  logic [IDX_W-1:0]   lk_req_idx,
  output logic               lk_rsp_valid,
  output logic [FIELD_W-1:0] lk_rsp_value
);
  logic              wr_en;
  logic [ENT_W-1:0]  wr_entry, rd_entry, lk_entry;
  logic [SL_W-1:0]   wr_slice;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic [ROW_W-1:0]  rd_row, lk_row;

  lut_axil_port #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W),
    .SLICES(SLICES), .ENT_W(ENT_W), .SL_W(SL_W)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .axi_awaddr(axi_awaddr), .axi_awvalid(axi_awvalid), .axi_awready(axi_awready),
    .axi_wdata(axi_wdata), .axi_wstrb(axi_wstrb), .axi_wvalid(axi_wvalid),
    .axi_wready(axi_wready), .axi_bresp(axi_bresp), .axi_bvalid(axi_bvalid),
    .axi_bready(axi_bready), .axi_araddr(axi_araddr), .axi_arvalid(axi_arvalid),
    .axi_arready(axi_arready), .axi_rdata(axi_rdata), .axi_rresp(axi_rresp),
    .axi_rvalid(axi_rvalid), .axi_rready(axi_rready),
    .wr_en(wr_en), .wr_entry(wr_entry), .wr_slice(wr_slice),
    .wr_data(wr_data), .wr_strb(wr_strb), .rd_entry(rd_entry), .rd_row(rd_row)
  );

  lut_store #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W), .SLICES(SLICES),
    .ENT_W(ENT_W), .SL_W(SL_W)
  ) u_store (
    .clk(clk), .wr_en(wr_en), .wr_entry(wr_entry), .wr_slice(wr_slice),
    .wr_data(wr_data), .wr_strb(wr_strb), .rd_entry(rd_entry), .rd_row(rd_row),
    .lk_entry(lk_entry), .lk_row(lk_row)
  );

  lut_field_pick #(
    .FIELDS(FIELDS), .FIELD_W(FIELD_W), .ROW_W(ROW_W),
    .ENT_W(ENT_W), .SLOT_W(SLOT_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n), .req_valid(lk_req_valid), .req_idx(lk_req_idx),
    .lk_entry(lk_entry), .lk_row(lk_row),
    .rsp_valid(lk_rsp_valid), .rsp_value(lk_rsp_value)
  );

  p_reset_quiet_r10 : assert property (@(posedge clk)
    !rst_n |=> !axi_bvalid && !axi_rvalid && !lk_rsp_valid);
endmodule

// File: tb/lut_axil_packed_bench.sv
`timescale 1ns/1ps
module lut_axil_packed_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] axi_awaddr = '0, axi_araddr = '0, axi_wdata = '0;
  logic [3:0]  axi_wstrb = '0;
  logic        axi_awvalid = 1'b0, axi_wvalid = 1'b0, axi_bready = 1'b0;
  logic        axi_arvalid = 1'b0, axi_rready = 1'b0;
  logic        axi_awready, axi_wready, axi_bvalid, axi_arready, axi_rvalid;
  logic [1:0]  axi_bresp, axi_rresp;
  logic [31:0] axi_rdata;
  logic        lk_req_valid = 1'b0;
  logic [10:0] lk_req_idx = '0;
  logic        lk_rsp_valid;
  logic [11:0] lk_rsp_value;

  int n_chk = 0;
  int n_fail = 0;
  logic [95:0] mdl [256];

  always #2 clk = ~clk;

  lut_axil_packed u_lut_axil_packed (
    .clk(clk), .rst_n(rst_n),
    .axi_awaddr(axi_awaddr), .axi_awvalid(axi_awvalid), .axi_awready(axi_awready),
    .axi_wdata(axi_wdata), .axi_wstrb(axi_wstrb), .axi_wvalid(axi_wvalid),
    .axi_wready(axi_wready), .axi_bresp(axi_bresp), .axi_bvalid(axi_bvalid),
    .axi_bready(axi_bready), .axi_araddr(axi_araddr), .axi_arvalid(axi_arvalid),
    .axi_arready(axi_arready), .axi_rdata(axi_rdata), .axi_rresp(axi_rresp),
    .axi_rvalid(axi_rvalid), .axi_rready(axi_rready),
    .lk_req_valid(lk_req_valid), .lk_req_idx(lk_req_idx),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_value(lk_rsp_value)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int n, input int k);
    return (32'(n) * 32'h9E3779B1) ^ (32'(k + 1) * 32'h85EBCA6B);
  endfunction

  function automatic logic [31:0] row_addr(input int n, input int k);
    return 32'h1000 + 32'(n * 16 + k * 4);
  endfunction

  // model update per R1/R2/R4/R5: only data words in the window, byte by byte
  task automatic model_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    int n, k;
    if (a >= 32'h1000 && a <= 32'h1FFF) begin
      n = int'((a - 32'h1000) >> 4);
      k = int'(((a - 32'h1000) >> 2) & 3);
      if (k < 3)
        for (int b = 0; b < 4; b++)
          if (s[b]) mdl[n][k*32 + b*8 +: 8] = d[b*8 +: 8];
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                           output logic [1:0] resp);
    @(negedge clk);
    axi_awaddr = a; axi_wdata = d; axi_wstrb = s;
    axi_awvalid = 1'b1; axi_wvalid = 1'b1; axi_bready = 1'b1;
    while (!axi_awready) @(negedge clk);
    @(negedge clk);
    axi_awvalid = 1'b0; axi_wvalid = 1'b0;
    while (!axi_bvalid) @(negedge clk);
    resp = axi_bresp;
    @(negedge clk);
    model_write(a, d, s);
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk);
    axi_araddr = a; axi_arvalid = 1'b1; axi_rready = 1'b1;
    while (!axi_arready) @(negedge clk);
    @(negedge clk);
    axi_arvalid = 1'b0;
    while (!axi_rvalid) @(negedge clk);
    d = axi_rdata; resp = axi_rresp;
    @(negedge clk);
  endtask

  // stream indices back to back; result checked two negedges after driving
  task automatic lookup_stream(input int first, input int count);
    int idx;
    for (int c = 0; c < count + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        idx = first + c - 2;
        chk(lk_rsp_valid, "R6 lookup valid", 64'(lk_rsp_valid), 64'd1);
        chk(lk_rsp_value == mdl[idx / 8][(idx % 8) * 12 +: 12], "R3 R6 lookup value",
            64'(lk_rsp_value), 64'(mdl[idx / 8][(idx % 8) * 12 +: 12]));
      end
      if (c < count) begin
        lk_req_valid = 1'b1;
        lk_req_idx = 11'(first + c);
      end else begin
        lk_req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(!lk_rsp_valid && lk_rsp_value == '0, "R7 idle after stream",
        {51'd0, lk_rsp_valid, lk_rsp_value}, 64'd0);
  endtask

  initial begin
    logic [1:0]  resp;
    logic [31:0] d;
    logic [3:0]  old_hi;

    repeat (3) @(negedge clk);
    chk(!axi_bvalid && !axi_rvalid && !lk_rsp_valid, "R10 reset outputs",
        {61'd0, axi_bvalid, axi_rvalid, lk_rsp_valid}, 64'd0);
    rst_n = 1'b1;

    // R1: fill every data word
    for (int n = 0; n < 256; n++)
      for (int k = 0; k < 3; k++) begin
        bus_write(row_addr(n, k), pat(n, k), 4'hF, resp);
        chk(resp == 2'b00, "R1 write okay", 64'(resp), 64'd0);
      end

    // R1 read back, R2 hole reads zero
    for (int n = 0; n < 256; n++)
      for (int k = 0; k < 4; k++) begin
        bus_read(row_addr(n, k) | 32'(k & 1), d, resp);
        if (k < 3)
          chk(d == pat(n, k) && resp == 2'b00, "R1 readback", {30'd0, resp, d}, {32'd0, pat(n, k)});
        else
          chk(d == '0 && resp == 2'b00, "R2 hole read", {30'd0, resp, d}, 64'd0);
      end

    // R3/R6/R7: every index, back to back
    lookup_stream(0, 2048);

    // R2: hole write ignored
    bus_write(row_addr(9, 3), 32'hDEADBEEF, 4'hF, resp);
    chk(resp == 2'b00, "R2 hole write okay", 64'(resp), 64'd0);
    bus_read(row_addr(9, 3), d, resp);
    chk(d == '0, "R2 hole stays zero", 64'(d), 64'd0);
    for (int k = 0; k < 3; k++) begin
      bus_read(row_addr(9, k), d, resp);
      chk(d == pat(9, k), "R2 neighbours untouched", 64'(d), 64'(pat(9, k)));
    end
    bus_read(row_addr(10, 0), d, resp);
    chk(d == pat(10, 0), "R2 next row untouched", 64'(d), 64'(pat(10, 0)));

    // R4: partial strobes
    bus_write(row_addr(5, 1), 32'h11223344, 4'b0101, resp);
    bus_read(row_addr(5, 1), d, resp);
    chk(d == mdl[5][63:32], "R4 strobe 0101", 64'(d), 64'(mdl[5][63:32]));
    chk(d[31:24] == pat(5, 1)[31:24] && d[23:16] == 8'h22, "R4 bytes kept/changed",
        64'(d), 64'({pat(5, 1)[31:24], 8'h22, pat(5, 1)[15:8], 8'h44}));
    bus_write(row_addr(5, 2), 32'hAABBCCDD, 4'b0000, resp);
    bus_read(row_addr(5, 2), d, resp);
    chk(d == pat(5, 2), "R4 empty strobe", 64'(d), 64'(pat(5, 2)));
    lookup_stream(5 * 8, 8);

    // R9: value 2 of row 7 straddles words 0 and 1
    old_hi = mdl[7][35:32];
    bus_write(row_addr(7, 0), 32'hFFFFFFFF, 4'hF, resp);
    @(negedge clk);
    lk_req_valid = 1'b1; lk_req_idx = 11'(7 * 8 + 2);
    @(negedge clk);
    lk_req_valid = 1'b0;
    @(negedge clk);
    chk(lk_rsp_valid && lk_rsp_value == {old_hi, 8'hFF}, "R9 half-updated straddle",
        64'(lk_rsp_value), 64'({old_hi, 8'hFF}));
    bus_write(row_addr(7, 1), 32'h0000000A, 4'b0001, resp);
    lookup_stream(7 * 8, 8);
    chk(mdl[7][35:24] == 12'hAFF, "R9 both words written", 64'(mdl[7][35:24]), 64'hAFF);

    // R5: out of window
    bus_write(32'h0000_0FFC, 32'h12345678, 4'hF, resp);
    chk(resp == 2'b10, "R5 low write slverr", 64'(resp), 64'd2);
    bus_write(32'h0000_2000, 32'h12345678, 4'hF, resp);
    chk(resp == 2'b10, "R5 high write slverr", 64'(resp), 64'd2);
    bus_read(32'h0001_1000, d, resp);
    chk(d == '0 && resp == 2'b10, "R5 alias read slverr", {30'd0, resp, d}, 64'd2 << 32);
    bus_read(32'h0000_0FFC, d, resp);
    chk(d == '0 && resp == 2'b10, "R5 low read slverr", {30'd0, resp, d}, 64'd2 << 32);
    bus_read(row_addr(0, 0), d, resp);
    chk(d == pat(0, 0), "R5 table unchanged", 64'(d), 64'(pat(0, 0)));
    bus_read(row_addr(255, 2), d, resp);
    chk(d == pat(255, 2) && resp == 2'b00, "R1 last word", 64'(d), 64'(pat(255, 2)));

    // R8: held write response, no second accept
    @(negedge clk);
    axi_awaddr = row_addr(3, 0); axi_wdata = 32'hCAFEF00D; axi_wstrb = 4'hF;
    axi_awvalid = 1'b1; axi_wvalid = 1'b0; axi_bready = 1'b0;
    @(negedge clk);
    chk(!axi_awready && !axi_bvalid, "R8 waits for data", {62'd0, axi_awready, axi_bvalid}, 64'd0);
    axi_wvalid = 1'b1;
    @(negedge clk);
    axi_awvalid = 1'b0; axi_wvalid = 1'b0;
    model_write(row_addr(3, 0), 32'hCAFEF00D, 4'hF);
    for (int w = 0; w < 3; w++) begin
      axi_awvalid = 1'b1; axi_wvalid = 1'b1;
      chk(axi_bvalid && axi_bresp == 2'b00 && !axi_awready, "R8 bresp held",
          {61'd0, axi_bvalid, axi_awready, 1'b0}, 64'd4);
      @(negedge clk);
    end
    axi_awvalid = 1'b0; axi_wvalid = 1'b0; axi_bready = 1'b1;
    @(negedge clk);
    chk(!axi_bvalid, "R8 bresp released", 64'(axi_bvalid), 64'd0);

    // R8: held read response
    @(negedge clk);
    axi_araddr = row_addr(3, 0); axi_arvalid = 1'b1; axi_rready = 1'b0;
    @(negedge clk);
    axi_araddr = row_addr(4, 0);
    for (int w = 0; w < 3; w++) begin
      chk(axi_rvalid && axi_rdata == 32'hCAFEF00D && !axi_arready, "R8 rdata held",
          64'(axi_rdata), 64'hCAFEF00D);
      @(negedge clk);
    end
    axi_arvalid = 1'b0; axi_rready = 1'b1;
    @(negedge clk);
    chk(!axi_rvalid, "R8 rdata released", 64'(axi_rvalid), 64'd0);

    // R7: gapped requests
    lk_req_valid = 1'b1; lk_req_idx = 11'd2047;
    @(negedge clk);
    lk_req_valid = 1'b0;
    @(negedge clk);
    chk(lk_rsp_valid && lk_rsp_value == mdl[255][95:84], "R6 last index",
        64'(lk_rsp_value), 64'(mdl[255][95:84]));
    @(negedge clk);
    chk(!lk_rsp_valid, "R7 single pulse", 64'(lk_rsp_valid), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule